// File: doc/BRIEF.md
# Connection Label Translation Stage

This block sits between header parsing and the switch fabric. Each cycle it may accept one parsed cell header made of a path label, a channel label, a payload-type code and a loss-priority bit. It looks the label pair up in a small table of connection entries. On a hit it rewrites the labels and sends the cell to the fabric output, with an internal routing tag in front that carries the output port, the service priority and a cell-type code. The tag is meaningful only inside the switch.

Signaling cells and maintenance cells never reach the table. They go to a local control output with a code that says which kind of special cell it is. A user cell whose labels match no valid entry is dropped, and a counter of unknown connections goes up by one.

An entry can be marked path-only. Such an entry matches on the path label alone and leaves the channel label as it arrived. A user-side mode input shortens the path label to its low 8 bits. In that mode the top 4 header bits are a flow-control nibble that passes through unchanged. Table entries are loaded through a write port. A write is held back until a cycle with no cell, so a cell is never looked up against a half-changed table.

Top module: `lbl_xlate_top`

## Requirements
- R1: After reset both output valids are low, `miss_count` is zero and every table entry is empty, so the first user cell misses.
- R2: A user cell whose path and channel labels match a valid full entry appears on the fabric output one clock after it is presented. It carries the entry's outgoing path label, outgoing channel label and output port.
- R3: A valid entry with `cfg_path_only` set matches on the path label alone. It replaces the path label and passes the incoming channel label unchanged.
- R4: When several valid entries match, the entry with the lowest index is used.
- R5: With `uni_if` high, only the low 8 path bits are compared, against an entry path label whose top 4 bits are zero. The outgoing path label is then {incoming bits 11:8, entry outgoing bits 7:0}. With `uni_if` low, all 12 bits are compared and replaced.
- R6: A cell with channel label 3 or 4 goes to the control output with `ctl_kind` = 1, whatever the table holds.
- R7: A cell with channel label 5 goes to the control output with `ctl_kind` = 0.
- R8: Any other cell with payload-type 4 or 5 goes to the control output with `ctl_kind` = 2.
- R9: `fab_tag` is {port[PORT_W-1:0], prio[PRIO_W-1:0], type[1:0]}. The type is 2 for payload-type 6, 3 for payload-type 7, and otherwise equals payload-type bit 0.
- R10: A user cell that matches no valid entry produces no output, and `miss_count` increases by exactly one.
- R11: A configuration write is committed on the first clock edge after the write edge at which `in_valid` is low. Cells presented before that edge use the old entry.
- R12: Payload-type and loss-priority bits pass through unchanged to whichever output takes the cell. The fabric and control valids are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uni_if | input | 1 | User-side label format (8-bit path label plus flow-control nibble) |
| in_valid | input | 1 | A header is presented this cycle |
| in_vpi | input | 12 | Incoming path label |
| in_vci | input | 16 | Incoming channel label |
| in_pt | input | 3 | Payload-type code |
| in_clp | input | 1 | Loss-priority bit |
| cfg_we | input | 1 | Table write request |
| cfg_idx | input | $clog2(ENTRIES) | Entry index to write |
| cfg_valid | input | 1 | Written entry is live |
| cfg_path_only | input | 1 | Written entry matches on the path label only |
| cfg_in_vpi | input | 12 | Entry key path label |
| cfg_in_vci | input | 16 | Entry key channel label |
| cfg_out_port | input | PORT_W | Entry output port |
| cfg_out_vpi | input | 12 | Entry outgoing path label |
| cfg_out_vci | input | 16 | Entry outgoing channel label |
| cfg_prio | input | PRIO_W | Entry service priority |
| fab_valid | output | 1 | Translated user cell valid |
| fab_tag | output | PORT_W+PRIO_W+2 | Internal routing tag |
| fab_vpi | output | 12 | Outgoing path label |
| fab_vci | output | 16 | Outgoing channel label |
| fab_pt | output | 3 | Payload-type code |
| fab_clp | output | 1 | Loss-priority bit |
| ctl_valid | output | 1 | Diverted special cell valid |
| ctl_kind | output | 2 | 0 signaling, 1 path maintenance, 2 channel maintenance |
| ctl_vpi | output | 12 | Path label of the diverted cell |
| ctl_vci | output | 16 | Channel label of the diverted cell |
| ctl_pt | output | 3 | Payload-type code of the diverted cell |
| ctl_clp | output | 1 | Loss-priority bit of the diverted cell |
| miss_count | output | CNT_W | Count of cells dropped for an unknown connection |

## Verification
A corrupted table entry or a wrong priority pick shows up one clock after the affected cell. It appears as a wrong port in `fab_tag` or a wrong rewritten label, or the cell vanishes while `miss_count` moves. A write committed too early shows up on the cell right after the write, which would carry the new mapping where the old one is expected. A bad classification appears in the same single cycle as a cell on the wrong output or a wrong `ctl_kind`. Random headers are drawn from narrow label ranges so that hits, misses, overlapping entries and special cells all occur often, next to directed cases for each corner.

// File: rtl/lbl_xlate_pkg.sv
package lbl_xlate_pkg;

    localparam int VPI_W     = 12;
    localparam int VCI_W     = 16;
    localparam int PT_W      = 3;
    localparam int GFC_W     = 4;
    localparam int UNI_VPI_W = VPI_W - GFC_W;

    typedef enum logic [1:0] {
        CK_SIG      = 2'd0,
        CK_PATH_OAM = 2'd1,
        CK_CHAN_OAM = 2'd2,
        CK_NONE     = 2'd3
    } ctl_kind_e;

    typedef struct packed {
        logic [VPI_W-1:0] vpi;
        logic [VCI_W-1:0] vci;
        logic [PT_W-1:0]  pt;
        logic             clp;
    } cell_hdr_t;

    function automatic ctl_kind_e classify(input cell_hdr_t h);
        if (h.vci == VCI_W'(3) || h.vci == VCI_W'(4)) return CK_PATH_OAM;
        if (h.vci == VCI_W'(5))                       return CK_SIG;
        if (h.pt == 3'd4 || h.pt == 3'd5)             return CK_CHAN_OAM;
        return CK_NONE;
    endfunction

    function automatic logic [1:0] cell_type(input logic [PT_W-1:0] pt);
        if (pt == 3'd6) return 2'd2;
        if (pt == 3'd7) return 2'd3;
        return {1'b0, pt[0]};
    endfunction

endpackage

// File: rtl/lbl_classify.sv
module lbl_classify
    import lbl_xlate_pkg::*;
(
    input  cell_hdr_t hdr,
    output logic      is_ctl,
    output ctl_kind_e kind
);
    always_comb begin
        kind   = classify(hdr);
        is_ctl = (kind != CK_NONE);
    end
endmodule

// File: rtl/lbl_table.sv
module lbl_table
    import lbl_xlate_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PORT_W  = 3,
    parameter int PRIO_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       busy,
    input  logic                       uni_if,
    input  logic [VPI_W-1:0]           key_vpi,
    input  logic [VCI_W-1:0]           key_vci,
    input  logic                       cfg_we,
    input  logic [$clog2(ENTRIES)-1:0] cfg_idx,
    input  logic                       cfg_valid,
    input  logic                       cfg_path_only,
    input  logic [VPI_W-1:0]           cfg_in_vpi,
    input  logic [VCI_W-1:0]           cfg_in_vci,
    input  logic [PORT_W-1:0]          cfg_out_port,
    input  logic [VPI_W-1:0]           cfg_out_vpi,
    input  logic [VCI_W-1:0]           cfg_out_vci,
    input  logic [PRIO_W-1:0]          cfg_prio,
    output logic                       hit,
    output logic                       hit_path_only,
    output logic [PORT_W-1:0]          hit_port,
    output logic [VPI_W-1:0]           hit_vpi,
    output logic [VCI_W-1:0]           hit_vci,
    output logic [PRIO_W-1:0]          hit_prio
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic              path_only;
        logic [VPI_W-1:0]  in_vpi;
        logic [VCI_W-1:0]  in_vci;
        logic [PORT_W-1:0] port;
        logic [VPI_W-1:0]  out_vpi;
        logic [VCI_W-1:0]  out_vci;
        logic [PRIO_W-1:0] prio;
    } entry_t;

    entry_t [ENTRIES-1:0] mem;
    entry_t               pend_ent;
    logic [IDX_W-1:0]     pend_idx;
    logic                 pend_vld;
    logic [ENTRIES-1:0]   match;
    entry_t               sel;
    logic [VPI_W-1:0]     uni_key;

    assign uni_key = {{GFC_W{1'b0}}, key_vpi[UNI_VPI_W-1:0]};

    // Writes wait in a one-deep holding slot until the cell stream pauses.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem      <= '0;
            pend_vld <= 1'b0;
            pend_idx <= '0;
            pend_ent <= '0;
        end else begin
            if (pend_vld && !busy) begin
                mem[pend_idx] <= pend_ent;
                pend_vld      <= 1'b0;
            end
            if (cfg_we) begin
                pend_vld <= 1'b1;
                pend_idx <= cfg_idx;
                pend_ent <= '{valid: cfg_valid, path_only: cfg_path_only,
                              in_vpi: cfg_in_vpi, in_vci: cfg_in_vci,
                              port: cfg_out_port, out_vpi: cfg_out_vpi,
                              out_vci: cfg_out_vci, prio: cfg_prio};
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = mem[g].valid
                        && (uni_if ? (mem[g].in_vpi == uni_key) : (mem[g].in_vpi == key_vpi))
                        && (mem[g].path_only || (mem[g].in_vci == key_vci));
    end

    // Lowest index wins: scan downward so the last overwrite is the smallest index.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = mem[i];
        end
    end

    assign hit           = sel.valid;
    assign hit_path_only = sel.path_only;
    assign hit_port      = sel.port;
    assign hit_vpi       = sel.out_vpi;
    assign hit_vci       = sel.out_vci;
    assign hit_prio      = sel.prio;

    // R11
    table_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mem));

endmodule

// File: rtl/lbl_xlate_top.sv
module lbl_xlate_top
    import lbl_xlate_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PORT_W  = 3,
    parameter int PRIO_W  = 2,
    parameter int CNT_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         uni_if,
    input  logic                         in_valid,
    input  logic [11:0]                  in_vpi,
    input  logic [15:0]                  in_vci,
    input  logic [2:0]                   in_pt,
    input  logic                         in_clp,
    input  logic                         cfg_we,
    input  logic [$clog2(ENTRIES)-1:0]   cfg_idx,
    input  logic                         cfg_valid,
    input  logic                         cfg_path_only,
    input  logic [11:0]                  cfg_in_vpi,
    input  logic [15:0]                  cfg_in_vci,
    input  logic [PORT_W-1:0]            cfg_out_port,
    input  logic [11:0]                  cfg_out_vpi,
    input  logic [15:0]                  cfg_out_vci,
    input  logic [PRIO_W-1:0]            cfg_prio,
    output logic                         fab_valid,
    output logic [PORT_W+PRIO_W+1:0]     fab_tag,
    output logic [11:0]                  fab_vpi,
    output logic [15:0]                  fab_vci,
    output logic [2:0]                   fab_pt,
    output logic                         fab_clp,
    output logic                         ctl_valid,
    output logic [1:0]                   ctl_kind,
    output logic [11:0]                  ctl_vpi,
    output logic [15:0]                  ctl_vci,
    output logic [2:0]                   ctl_pt,
    output logic                         ctl_clp,
    output logic [CNT_W-1:0]             miss_count
);
    cell_hdr_t         hdr;
    logic              is_ctl;
    ctl_kind_e         kind;
    logic              hit, hit_po;
    logic [PORT_W-1:0] hit_port;
    logic [VPI_W-1:0]  hit_vpi, new_vpi;
    logic [VCI_W-1:0]  hit_vci, new_vci;
    logic [PRIO_W-1:0] hit_prio;
    logic              user_cell;

    assign hdr       = '{vpi: in_vpi, vci: in_vci, pt: in_pt, clp: in_clp};
    assign user_cell = in_valid && !is_ctl;

    lbl_classify u_cls (
        .hdr    (hdr),
        .is_ctl (is_ctl),
        .kind   (kind)
    );

    lbl_table #(.ENTRIES(ENTRIES), .PORT_W(PORT_W), .PRIO_W(PRIO_W)) u_tbl (
        .clk           (clk),
        .rst           (rst),
        .busy          (in_valid),
        .uni_if        (uni_if),
        .key_vpi       (in_vpi),
        .key_vci       (in_vci),
        .cfg_we        (cfg_we),
        .cfg_idx       (cfg_idx),
        .cfg_valid     (cfg_valid),
        .cfg_path_only (cfg_path_only),
        .cfg_in_vpi    (cfg_in_vpi),
        .cfg_in_vci    (cfg_in_vci),
        .cfg_out_port  (cfg_out_port),
        .cfg_out_vpi   (cfg_out_vpi),
        .cfg_out_vci   (cfg_out_vci),
        .cfg_prio      (cfg_prio),
        .hit           (hit),
        .hit_path_only (hit_po),
        .hit_port      (hit_port),
        .hit_vpi       (hit_vpi),
        .hit_vci       (hit_vci),
        .hit_prio      (hit_prio)
    );

    // The flow-control nibble survives in the user-side format.
    assign new_vpi = uni_if ? {in_vpi[VPI_W-1:UNI_VPI_W], hit_vpi[UNI_VPI_W-1:0]} : hit_vpi;
    assign new_vci = hit_po ? in_vci : hit_vci;

    always_ff @(posedge clk) begin
        if (rst) begin
            fab_valid  <= 1'b0;
            ctl_valid  <= 1'b0;
            miss_count <= '0;
            fab_tag    <= '0;
            fab_vpi    <= '0;
            fab_vci    <= '0;
            fab_pt     <= '0;
            fab_clp    <= 1'b0;
            ctl_kind   <= '0;
            ctl_vpi    <= '0;
            ctl_vci    <= '0;
            ctl_pt     <= '0;
            ctl_clp    <= 1'b0;
        end else begin
            fab_valid <= user_cell && hit;
            ctl_valid <= in_valid && is_ctl;
            if (user_cell && !hit) miss_count <= miss_count + 1'b1;
            if (user_cell && hit) begin
                fab_tag <= {hit_port, hit_prio, cell_type(in_pt)};
                fab_vpi <= new_vpi;
                fab_vci <= new_vci;
                fab_pt  <= in_pt;
                fab_clp <= in_clp;
            end
            if (in_valid && is_ctl) begin
                ctl_kind <= kind;
                ctl_vpi  <= in_vpi;
                ctl_vci  <= in_vci;
                ctl_pt   <= in_pt;
                ctl_clp  <= in_clp;
            end
        end
    end

    // R12
    one_dest_chk: assert property (@(posedge clk) disable iff (rst)
        !(fab_valid && ctl_valid));

    // R12
    pt_pass_chk: assert property (@(posedge clk) disable iff (rst)
        fab_valid |-> (fab_pt == $past(in_pt) && fab_clp == $past(in_clp)));

    // R2
    out_src_chk: assert property (@(posedge clk) disable iff (rst)
        (fab_valid || ctl_valid) |-> $past(in_valid));

    // R10
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_count != $past(miss_count)) |->
            ($past(in_valid) && !fab_valid && !ctl_valid
             && miss_count == $past(miss_count) + 1'b1));

endmodule

// File: tb/lbl_xlate_tb.sv
`timescale 1ns/1ps
module lbl_xlate_top_tb_top;
    localparam int ENTRIES = 8;
    localparam int PORT_W  = 3;
    localparam int PRIO_W  = 2;
    localparam int CNT_W   = 16;
    localparam int TAG_W   = PORT_W + PRIO_W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic uni_if = 0, in_valid = 0, in_clp = 0;
    logic [11:0] in_vpi = 0;
    logic [15:0] in_vci = 0;
    logic [2:0]  in_pt = 0;
    logic cfg_we = 0, cfg_valid = 0, cfg_path_only = 0;
    logic [2:0]  cfg_idx = 0;
    logic [11:0] cfg_in_vpi = 0, cfg_out_vpi = 0;
    logic [15:0] cfg_in_vci = 0, cfg_out_vci = 0;
    logic [PORT_W-1:0] cfg_out_port = 0;
    logic [PRIO_W-1:0] cfg_prio = 0;
    logic fab_valid, fab_clp, ctl_valid, ctl_clp;
    logic [TAG_W-1:0] fab_tag;
    logic [11:0] fab_vpi, ctl_vpi;
    logic [15:0] fab_vci, ctl_vci;
    logic [2:0]  fab_pt, ctl_pt;
    logic [1:0]  ctl_kind;
    logic [CNT_W-1:0] miss_count;

    lbl_xlate_top #(.ENTRIES(ENTRIES), .PORT_W(PORT_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .uni_if(uni_if), .in_valid(in_valid),
        .in_vpi(in_vpi), .in_vci(in_vci), .in_pt(in_pt), .in_clp(in_clp),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_path_only(cfg_path_only), .cfg_in_vpi(cfg_in_vpi), .cfg_in_vci(cfg_in_vci),
        .cfg_out_port(cfg_out_port), .cfg_out_vpi(cfg_out_vpi), .cfg_out_vci(cfg_out_vci),
        .cfg_prio(cfg_prio), .fab_valid(fab_valid), .fab_tag(fab_tag), .fab_vpi(fab_vpi),
        .fab_vci(fab_vci), .fab_pt(fab_pt), .fab_clp(fab_clp), .ctl_valid(ctl_valid),
        .ctl_kind(ctl_kind), .ctl_vpi(ctl_vpi), .ctl_vci(ctl_vci), .ctl_pt(ctl_pt),
        .ctl_clp(ctl_clp), .miss_count(miss_count)
    );

    int checks = 0;
    int errors = 0;

    // Reference table kept by the bench
    logic        m_v   [ENTRIES];
    logic        m_po  [ENTRIES];
    logic [11:0] m_ivpi[ENTRIES];
    logic [15:0] m_ivci[ENTRIES];
    logic [PORT_W-1:0] m_port[ENTRIES];
    logic [11:0] m_ovpi[ENTRIES];
    logic [15:0] m_ovci[ENTRIES];
    logic [PRIO_W-1:0] m_prio[ENTRIES];
    logic [CNT_W-1:0] m_cnt = 0;

    // Expected outcome: 0 fabric, 1 control, 2 dropped
    int          e_dest;
    logic [1:0]  e_kind;
    logic [TAG_W-1:0] e_tag;
    logic [11:0] e_vpi;
    logic [15:0] e_vci;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_type(input logic [2:0] pt);
        if (pt == 3'd6) return 2'd2;
        if (pt == 3'd7) return 2'd3;
        return {1'b0, pt[0]};
    endfunction

    task automatic predict(input logic uni, input logic [11:0] vpi, input logic [15:0] vci,
                           input logic [2:0] pt);
        int found = -1;
        if (vci == 16'd3 || vci == 16'd4) begin e_dest = 1; e_kind = 2'd1; return; end
        if (vci == 16'd5)                 begin e_dest = 1; e_kind = 2'd0; return; end
        if (pt == 3'd4 || pt == 3'd5)     begin e_dest = 1; e_kind = 2'd2; return; end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            bit pm = uni ? (m_ivpi[i] == {4'h0, vpi[7:0]}) : (m_ivpi[i] == vpi);
            if (m_v[i] && pm && (m_po[i] || m_ivci[i] == vci)) found = i;
        end
        if (found < 0) begin e_dest = 2; m_cnt = m_cnt + 1'b1; return; end
        e_dest = 0;
        e_tag  = {m_port[found], m_prio[found], exp_type(pt)};
        e_vpi  = uni ? {vpi[11:8], m_ovpi[found][7:0]} : m_ovpi[found];
        e_vci  = m_po[found] ? vci : m_ovci[found];
    endtask

    // Called at a falling edge, returns at the next falling edge.
    task automatic send_cell(input logic uni, input logic [11:0] vpi, input logic [15:0] vci,
                             input logic [2:0] pt, input logic clp, input string req);
        uni_if = uni; in_valid = 1; in_vpi = vpi; in_vci = vci; in_pt = pt; in_clp = clp;
        predict(uni, vpi, vci, pt);
        @(posedge clk); #1;
        if (e_dest == 0) begin
            check(fab_valid && !ctl_valid && fab_tag == e_tag && fab_vpi == e_vpi
                  && fab_vci == e_vci && fab_pt == pt && fab_clp == clp, req, "fabric cell",
                  {fab_valid, ctl_valid, fab_tag, fab_vpi, fab_vci, fab_pt, fab_clp},
                  {1'b1, 1'b0, e_tag, e_vpi, e_vci, pt, clp});
        end else if (e_dest == 1) begin
            check(ctl_valid && !fab_valid && ctl_kind == e_kind && ctl_vpi == vpi
                  && ctl_vci == vci && ctl_pt == pt && ctl_clp == clp, req, "control cell",
                  {ctl_valid, fab_valid, ctl_kind, ctl_vpi, ctl_vci, ctl_pt, ctl_clp},
                  {1'b1, 1'b0, e_kind, vpi, vci, pt, clp});
        end else begin
            check(!fab_valid && !ctl_valid && miss_count == m_cnt, req, "dropped cell",
                  {fab_valid, ctl_valid, miss_count}, {2'b00, m_cnt});
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_cfg(input int idx, input logic v, input logic po,
                             input logic [11:0] ivpi, input logic [15:0] ivci,
                             input logic [PORT_W-1:0] port, input logic [11:0] ovpi,
                             input logic [15:0] ovci, input logic [PRIO_W-1:0] prio);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_valid = v; cfg_path_only = po;
        cfg_in_vpi = ivpi; cfg_in_vci = ivci; cfg_out_port = port;
        cfg_out_vpi = ovpi; cfg_out_vci = ovci; cfg_prio = prio;
    endtask

    task automatic model_cfg(input int idx, input logic v, input logic po,
                             input logic [11:0] ivpi, input logic [15:0] ivci,
                             input logic [PORT_W-1:0] port, input logic [11:0] ovpi,
                             input logic [15:0] ovci, input logic [PRIO_W-1:0] prio);
        m_v[idx] = v; m_po[idx] = po; m_ivpi[idx] = ivpi; m_ivci[idx] = ivci;
        m_port[idx] = port; m_ovpi[idx] = ovpi; m_ovci[idx] = ovci; m_prio[idx] = prio;
    endtask

    task automatic cfg_write(input int idx, input logic v, input logic po,
                             input logic [11:0] ivpi, input logic [15:0] ivci,
                             input logic [PORT_W-1:0] port, input logic [11:0] ovpi,
                             input logic [15:0] ovci, input logic [PRIO_W-1:0] prio);
        in_valid = 0;
        drive_cfg(idx, v, po, ivpi, ivci, port, ovpi, ovci, prio);
        @(negedge clk);
        cfg_we = 0;
        @(negedge clk);
        model_cfg(idx, v, po, ivpi, ivci, port, ovpi, ovci, prio);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < ENTRIES; i++) model_cfg(i, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state and empty table
        check(!fab_valid && !ctl_valid && miss_count == 0, "R1", "reset outputs",
              {fab_valid, ctl_valid, miss_count}, 64'd0);
        send_cell(0, 12'h001, 16'd40, 3'd0, 0, "R1");

        // R2, R9: full entry
        cfg_write(0, 1, 0, 12'h001, 16'd40, 3'd5, 12'h123, 16'h0777, 2'd2);
        send_cell(0, 12'h001, 16'd40, 3'd0, 0, "R2");
        send_cell(0, 12'h001, 16'd40, 3'd1, 1, "R9");
        send_cell(0, 12'h001, 16'd40, 3'd6, 0, "R9");
        send_cell(0, 12'h001, 16'd40, 3'd7, 1, "R9");
        send_cell(0, 12'h001, 16'd41, 3'd0, 0, "R10");

        // R3: path-only entry keeps the channel label
        cfg_write(1, 1, 1, 12'h002, 16'd0, 3'd3, 12'h0AB, 16'hFFFF, 2'd1);
        send_cell(0, 12'h002, 16'h0099, 3'd0, 0, "R3");
        send_cell(0, 12'h002, 16'h1234, 3'd2, 1, "R3");

        // R4: lowest index among overlapping entries
        cfg_write(3, 1, 0, 12'h007, 16'd50, 3'd6, 12'h333, 16'h0333, 2'd3);
        cfg_write(2, 1, 0, 12'h007, 16'd50, 3'd2, 12'h222, 16'h0222, 2'd0);
        send_cell(0, 12'h007, 16'd50, 3'd0, 0, "R4");

        // R5: user-side format against network-side format
        cfg_write(4, 1, 0, 12'h011, 16'd60, 3'd4, 12'h5C7, 16'h0600, 2'd1);
        send_cell(1, 12'hA11, 16'd60, 3'd0, 0, "R5");
        send_cell(0, 12'hA11, 16'd60, 3'd0, 0, "R5");
        send_cell(0, 12'h011, 16'd60, 3'd0, 0, "R5");

        // R6, R7, R8: special cells bypass the table
        send_cell(0, 12'h001, 16'd3, 3'd0, 0, "R6");
        send_cell(0, 12'h0FF, 16'd4, 3'd5, 1, "R6");
        send_cell(0, 12'h001, 16'd5, 3'd0, 0, "R7");
        send_cell(0, 12'h001, 16'd40, 3'd4, 0, "R8");
        send_cell(0, 12'h001, 16'd40, 3'd5, 1, "R8");

        // R11: a write presented just before a burst waits for the gap
        in_valid = 0;
        drive_cfg(0, 1, 0, 12'h001, 16'd40, 3'd1, 12'h456, 16'h0888, 2'd0);
        @(negedge clk);
        cfg_we = 0;
        send_cell(0, 12'h001, 16'd40, 3'd0, 0, "R11");
        send_cell(0, 12'h001, 16'd40, 3'd0, 0, "R11");
        idle(1);
        model_cfg(0, 1, 0, 12'h001, 16'd40, 3'd1, 12'h456, 16'h0888, 2'd0);
        send_cell(0, 12'h001, 16'd40, 3'd0, 0, "R11");
        idle(1);

        // Random table and traffic, R2/R12 and the rest
        for (int i = 0; i < ENTRIES; i++) begin
            logic [11:0] kv = 12'($urandom_range(0, 5));
            if ($urandom_range(0, 3) == 0) kv[11:8] = 4'($urandom_range(1, 15));
            cfg_write(i, 1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 3) == 0), kv,
                      16'($urandom_range(32, 39)), PORT_W'($urandom), 12'($urandom),
                      16'($urandom), PRIO_W'($urandom));
        end
        for (int n = 0; n < 400; n++) begin
            logic [11:0] v = 12'($urandom_range(0, 5));
            logic [15:0] c;
            int sel = $urandom_range(0, 9);
            if ($urandom_range(0, 2) == 0) v[11:8] = 4'($urandom);
            c = (sel == 0) ? 16'd3 : (sel == 1) ? 16'd4 : (sel == 2) ? 16'd5
                                   : 16'($urandom_range(32, 39));
            send_cell(1'($urandom), v, c, 3'($urandom), 1'($urandom), "R2/R12");
            if ($urandom_range(0, 49) == 0) begin
                cfg_write($urandom_range(0, ENTRIES - 1), 1'b1, 1'($urandom),
                          12'($urandom_range(0, 5)), 16'($urandom_range(32, 39)),
                          PORT_W'($urandom), 12'($urandom), 16'($urandom), PRIO_W'($urandom));
            end
        end
        idle(2);
        check(miss_count == m_cnt, "R10", "final miss count", 64'(miss_count), 64'(m_cnt));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule